// File: doc/BRIEF.md
# UART Interrupt Enable, Mask and Status Bank

This block holds the interrupt bookkeeping for a serial port. Thirteen single-cycle event pulses from the port's datapath are caught in a sticky status register. Software clears a status bit by writing 1 to it. A mask register decides which caught events may raise the single interrupt line.

Software never writes the mask directly. A write to the arm register sets every mask bit where the write data holds a 1. A write to the disarm register clears every mask bit where the write data holds a 1. The mask itself can be read at its own address, and writes to that address are ignored. This lets several software agents change separate sources without a read-modify-write race.

Access is through a plain register bus with a byte address, write data and a write strobe. It also has a read strobe, and read data that is registered one cycle after the strobe. The reset input is asserted asynchronously and released in step with the clock through a two-stage synchronizer.

Top module: `uart_irq_bank`

## Requirements
- R1: Source bits sit at fixed positions in every register and in `evt_pulse`: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit trigger, 11 transmit nearly full, 12 transmit overflow.
- R2: A write to the arm register (offset 0x08) sets each mask bit whose write-data bit is 1; write-data bits of 0 leave the mask unchanged.
- R3: A write to the disarm register (offset 0x0C) clears each mask bit whose write-data bit is 1; write-data bits of 0 leave the mask unchanged.
- R4: The mask reads back at offset 0x10. Writes to offset 0x10 have no effect. Reads of offsets 0x08 and 0x0C return zero.
- R5: A 1 on `evt_pulse[i]` sets status bit i one cycle later. The bit stays set until it is cleared; the status reads back at offset 0x14.
- R6: A write to offset 0x14 clears each status bit whose write-data bit is 1; write-data bits of 0 leave the status unchanged.
- R7: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set afterwards.
- R8: `irq` is high exactly when some bit is set in both status and mask. It follows the register state with no further delay.
- R9: While reset is applied and after its release, mask and status are zero, `irq` is low and `bus_rdata` is zero.
- R10: Read-data bits 31 down to 13 are always zero, and reads of any other offset return zero.
- R11: `bus_rdata` takes the addressed value on the clock edge where `bus_re` is high, and holds it while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 13 | Event pulses from the datapath, one bit per source |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the address is valid whenever a strobe is high. They also assume that `evt_pulse` carries known values in every cycle after reset, since any X would be caught in a sticky bit. The bench changes all inputs only on the falling clock edge and holds the event pulses at zero between scenarios. Each scenario issues at most one write per cycle, so the arm/disarm collision can only arise inside the mask logic, never from the bus.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // register selector decoded from the bus address
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ARM,
    SEL_DISARM,
    SEL_MASK,
    SEL_STAT
  } reg_sel_e;

  // source positions (fixed; shared by every register of the bank)
  localparam int unsigned SRC_RX_TRIG  = 0;
  localparam int unsigned SRC_RX_EMPTY = 1;
  localparam int unsigned SRC_RX_FULL  = 2;
  localparam int unsigned SRC_TX_EMPTY = 3;
  localparam int unsigned SRC_TX_FULL  = 4;
  localparam int unsigned SRC_RX_OVR   = 5;
  localparam int unsigned SRC_FRAME    = 6;
  localparam int unsigned SRC_PARITY   = 7;
  localparam int unsigned SRC_TIMEOUT  = 8;
  localparam int unsigned SRC_MODEM    = 9;
  localparam int unsigned SRC_TX_TRIG  = 10;
  localparam int unsigned SRC_TX_NFULL = 11;
  localparam int unsigned SRC_TX_OVR   = 12;
  localparam int unsigned SRC_COUNT    = 13;

endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_SRC    = 13,
  parameter logic [ADDR_W-1:0] OFF_ARM    = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_DISARM = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_STAT   = 8'h14
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output reg_sel_e          sel,
  output logic [N_SRC-1:0]  arm_vec,
  output logic [N_SRC-1:0]  disarm_vec,
  output logic [N_SRC-1:0]  w1c_vec
);

  logic [N_SRC-1:0] wbits;

  assign wbits = bus_wdata[N_SRC-1:0];

  always_comb begin
    if      (bus_addr == OFF_ARM)    sel = SEL_ARM;
    else if (bus_addr == OFF_DISARM) sel = SEL_DISARM;
    else if (bus_addr == OFF_MASK)   sel = SEL_MASK;
    else if (bus_addr == OFF_STAT)   sel = SEL_STAT;
    else                             sel = SEL_NONE;
  end

  // write of the mask view (SEL_MASK) produces no strobe: it is read-only
  always_comb begin
    arm_vec    = '0;
    disarm_vec = '0;
    w1c_vec    = '0;
    if (bus_we) begin
      unique case (sel)
        SEL_ARM:    arm_vec    = wbits;
        SEL_DISARM: disarm_vec = wbits;
        SEL_STAT:   w1c_vec    = wbits;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] arm_vec,
  input  logic [N_SRC-1:0] disarm_vec,
  output logic [N_SRC-1:0] mask_q
);

  logic [N_SRC-1:0] mask_nxt;
  logic             mask_en;

  // clearing takes priority over setting for the same bit
  always_comb begin
    mask_en  = (|arm_vec) | (|disarm_vec);
    mask_nxt = (mask_q | arm_vec) & ~disarm_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_nxt;
  end

  // R2: armed bits are set on the following cycle
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_vec & ~disarm_vec) != '0) |=>
      ((mask_q & $past(arm_vec & ~disarm_vec)) == $past(arm_vec & ~disarm_vec)));

  // R3: disarmed bits are clear on the following cycle
  a_r3_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_vec != '0) |=> ((mask_q & $past(disarm_vec)) == '0));

  // R2/R3: with no strobe the mask holds
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_vec == '0) && (disarm_vec == '0)) |=> $stable(mask_q));

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_pulse,
  input  logic [N_SRC-1:0] w1c_vec,
  output logic [N_SRC-1:0] stat_q
);

  logic [N_SRC-1:0] stat_nxt;
  logic             stat_en;

  // per-source sticky bit: an event beats a clear in the same cycle
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign stat_nxt[i] = evt_pulse[i] | (stat_q[i] & ~w1c_vec[i]);
  end

  assign stat_en = (|evt_pulse) | (|w1c_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end

  // R5, R7: an event always leaves its bit set
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R5: a set bit falls only under a clearing write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> (($past(stat_q) & ~$past(w1c_vec) & ~stat_q) == '0));

  // R6: a cleared bit without a coincident event is zero afterwards
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_vec != '0) |=> ((stat_q & $past(w1c_vec & ~evt_pulse)) == '0));

endmodule

// File: rtl/uart_irq_rdport.sv
module uart_irq_rdport
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_re,
  input  reg_sel_e          sel,
  input  logic [N_SRC-1:0]  mask_q,
  input  logic [N_SRC-1:0]  stat_q,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    unique case (sel)
      SEL_MASK: rdata_nxt = {{PAD_W{1'b0}}, mask_q};
      SEL_STAT: rdata_nxt = {{PAD_W{1'b0}}, stat_q};
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_nxt;
  end

  // R10: the padding above the sources never carries a 1
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[DATA_W-1:N_SRC] == '0);

  // R11: read data holds when no read is strobed
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(rdata_q));

  // R4: write-only registers read as zero
  a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (sel == SEL_ARM || sel == SEL_DISARM)) |=> (rdata_q == '0));

endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = SRC_COUNT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFF_ARM    = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_DISARM = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_STAT   = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  output logic              irq
);

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic [N_SRC-1:0] arm_vec;
  logic [N_SRC-1:0] disarm_vec;
  logic [N_SRC-1:0] w1c_vec;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] stat_q;

  uart_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_irq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC),
    .OFF_ARM(OFF_ARM), .OFF_DISARM(OFF_DISARM),
    .OFF_MASK(OFF_MASK), .OFF_STAT(OFF_STAT)
  ) u_dec (
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .sel        (sel),
    .arm_vec    (arm_vec),
    .disarm_vec (disarm_vec),
    .w1c_vec    (w1c_vec)
  );

  uart_irq_mask #(.N_SRC(N_SRC)) u_mask (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .arm_vec    (arm_vec),
    .disarm_vec (disarm_vec),
    .mask_q     (mask_q)
  );

  uart_irq_status #(.N_SRC(N_SRC)) u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_pulse (evt_pulse),
    .w1c_vec   (w1c_vec),
    .stat_q    (stat_q)
  );

  uart_irq_rdport #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bus_re  (bus_re),
    .sel     (sel),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .rdata_q (bus_rdata)
  );

  assign irq = |(stat_q & mask_q);

  // R8: a pending unmasked event raises irq in the next cycle
  a_r8_evt_to_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((evt_pulse & mask_q & ~disarm_vec) != '0) |=> irq);

  // R9: nothing pending while in reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq && bus_rdata == '0));

endmodule

// File: tb/test_uart_irq_bank.sv
`timescale 1ns/1ps
module test_uart_irq_bank;

  localparam logic [7:0] A_ARM    = 8'h08;
  localparam logic [7:0] A_DISARM = 8'h0C;
  localparam logic [7:0] A_MASK   = 8'h10;
  localparam logic [7:0] A_STAT   = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [12:0] evt_pulse;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [12:0] m_mask;
  logic [12:0] m_stat;

  always #2.5 clk = ~clk;

  uart_irq_bank i_uart_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [12:0] ev);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; evt_pulse = ev;
    @(negedge clk);
    bus_we = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [12:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic exp_irq();
    return |(m_stat & m_mask);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R9 irq in reset", {31'b0, irq}, 32'h0);
    check("R9 rdata in reset", bus_rdata, 32'h0);
    rd(A_MASK, d); check("R9 mask after reset", d, 32'h0);
    rd(A_STAT, d); check("R9 status after reset", d, 32'h0);
  endtask

  task automatic t_arm();
    logic [31:0] d;
    wr(A_ARM, 32'h0000_0005, '0); m_mask = 13'h0005;
    rd(A_MASK, d); check("R2 arm sets", d, {19'b0, m_mask});
    wr(A_ARM, 32'h0, '0);
    rd(A_MASK, d); check("R2 zero arm no effect", d, {19'b0, m_mask});
    rd(A_ARM, d); check("R4 arm reads zero", d, 32'h0);
  endtask

  task automatic t_disarm();
    logic [31:0] d;
    wr(A_DISARM, 32'h1, '0); m_mask = 13'h0004;
    rd(A_MASK, d); check("R3 disarm clears", d, {19'b0, m_mask});
    wr(A_DISARM, 32'h0, '0);
    rd(A_MASK, d); check("R3 zero disarm no effect", d, {19'b0, m_mask});
    rd(A_DISARM, d); check("R4 disarm reads zero", d, 32'h0);
    wr(A_MASK, 32'h1FFF, '0);
    rd(A_MASK, d); check("R4 mask write ignored", d, {19'b0, m_mask});
  endtask

  task automatic t_positions();
    logic [31:0] d;
    for (int i = 0; i < 13; i++) begin
      pulse(13'(1) << i);
      rd(A_STAT, d); check("R1 source position", d, 32'(1) << i);
      wr(A_STAT, 32'h1FFF, '0);
    end
    m_stat = '0;
  endtask

  task automatic t_sticky_irq();
    logic [31:0] d;
    pulse(13'h1000); m_stat = 13'h1000;
    check("R8 masked-off event no irq", {31'b0, irq}, {31'b0, exp_irq()});
    pulse(13'h0001); m_stat = 13'h1001;
    repeat (5) @(negedge clk);
    rd(A_STAT, d); check("R5 status sticky", d, {19'b0, m_stat});
    wr(A_ARM, 32'h1000, '0); m_mask = 13'h1004;
    check("R8 irq after arm", {31'b0, irq}, {31'b0, exp_irq()});
    pulse(13'h0004); m_stat = 13'h1005;
    check("R8 irq with two pending", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_STAT, 32'h0, '0);
    rd(A_STAT, d); check("R6 zero write keeps status", d, {19'b0, m_stat});
    wr(A_STAT, 32'h1004, '0); m_stat = 13'h0001;
    rd(A_STAT, d); check("R6 w1c clears", d, {19'b0, m_stat});
    check("R8 irq drops after clear", {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(A_STAT, 32'h0001, 13'h0001);
    rd(A_STAT, d); check("R7 event wins over clear", d, {19'b0, m_stat});
    wr(A_STAT, 32'h0001, '0); m_stat = '0;
    rd(A_STAT, d); check("R7 later clear works", d, 32'h0);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(A_ARM, 32'hFFFF_FFFF, '0); m_mask = 13'h1FFF;
    rd(A_MASK, d); check("R10 upper bits zero", d, 32'h0000_1FFF);
    rd(8'h00, d); check("R10 unmapped read zero", d, 32'h0);
    rd(8'h18, d); check("R10 unmapped read zero 0x18", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(A_MASK, d);
    wr(A_DISARM, 32'h1FFF, '0); m_mask = '0;
    repeat (2) @(negedge clk);
    check("R11 rdata held without read", bus_rdata, 32'h0000_1FFF);
    rd(A_MASK, d); check("R11 new read updates", d, 32'h0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    evt_pulse = '0; m_mask = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_arm();
    t_disarm();
    t_positions();
    t_sticky_irq();
    t_w1c();
    t_collide();
    t_upper();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule